// File: doc/BRIEF.md
# Double-Buffered SPI Serial Port

This block is an 8-bit SPI port for a host processor. It runs either as the bus master, generating the serial clock from the system clock, or as a slave clocked by an external device. The idle level of the serial clock, the edge that launches output bits and the point at which input bits are sampled are all set by configuration inputs. In master mode a rate code selects the serial clock frequency. In slave mode a select input can gate the port.

The host has a single data register. A write to it loads the internal shift register. In master mode, that write also starts a transfer. A read returns the last completed byte. Each completed byte is copied into that register, so the next byte can shift in before the host has read the previous one. Status outputs report a full buffer, a rejected write, a lost byte and an interrupt request. Each sticky flag has its own clear strobe.

Top module: `spi_dbuf_port`

## Requirements
- R1: Bits move through the shift register most significant bit first, both at `sdo` and at `sdi`.
- R2: In master mode `sck_out` rests at `cfg_cpol` between transfers. A transfer toggles it 16 times and keeps `busy` high for 17 half periods. A half period is 2, 8 or 32 system clocks for `cfg_rate` 0, 1 or 2, and 32 for code 3.
- R3: With `cfg_cke`=1, output bits change on active-to-idle clock edges, and the first bit is on `sdo` from the moment of the write. With `cfg_cke`=0, output bits change on idle-to-active edges. In master mode `cfg_smp`=0 samples `sdi` in the middle of each output bit and `cfg_smp`=1 samples it at the end.
- R4: When a byte completes it is copied to `host_rdata`, and `stat_bf` and `irq` are set. In master mode this happens in the same cycle that `busy` falls.
- R5: A `host_rd` pulse clears `stat_bf` one cycle later. It leaves `host_rdata` unchanged.
- R6: A `host_wr` while `busy` is high is discarded and sets `stat_wcol`. The flag stays set until `clr_wcol` is pulsed.
- R7: A byte that completes while `stat_bf` is still set is dropped. `host_rdata` keeps the old byte and `stat_ovf` is set until `clr_ovf` is pulsed.
- R8: `irq` stays set through buffer reads and is cleared only by `clr_irq`.
- R9: In slave mode the port shifts on edges of `sck_in`, with the same launch and sample edges as R3 for `cfg_smp`=0. A byte completes on the eighth sampling edge.
- R10: In slave mode with `cfg_ss_en`=1, a high `ss_n` drives `sdo_oe` low and discards any partial byte, so `busy` returns low. With `cfg_ss_en`=0, `ss_n` is ignored and `sdo_oe` is high. In master mode `sdo_oe` and `sck_oe` are high.
- R11: After reset, all flags and `busy` are low and `sck_out` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cke | input | 1 | 1 = launch on active-to-idle edge, 0 = launch on idle-to-active edge |
| cfg_smp | input | 1 | Master sample point: 0 = middle of bit, 1 = end of bit |
| cfg_rate | input | 2 | Master clock rate code (divide by 4, 16, 64, 64) |
| cfg_ss_en | input | 1 | Slave select gating enable |
| host_wr | input | 1 | Write strobe for the data register |
| host_wdata | input | W | Byte to send |
| host_rd | input | 1 | Read strobe for the data register |
| host_rdata | output | W | Last completed received byte |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| clr_irq | input | 1 | Clears the interrupt request |
| stat_bf | output | 1 | Receive buffer holds an unread byte |
| stat_wcol | output | 1 | A write arrived during a transfer |
| stat_ovf | output | 1 | A received byte was dropped |
| irq | output | 1 | Byte-complete interrupt request |
| busy | output | 1 | Transfer in progress |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_in | input | 1 | Serial clock received in slave mode |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
In master mode a byte is due exactly 17 half periods after the write. The bench counts the falling edges of the system clock while `busy` is high, compares that count with 17 times the half period for the rate code, and then checks `host_rdata`, `stat_bf` and `irq` on the falling edge where `busy` is first seen low. In slave mode every edge of `sck_in` and every `sdi` bit reaches the shift logic three clocks later, after two synchronizer stages and an edge register. The bench therefore holds each serial clock level for eight clocks and reads `sdo` only just before its next edge. Flag strobes take effect on the next clock, so each flag is checked on the falling edge after the strobe is removed.

// File: rtl/spi_dbuf_port.sv
module spi_dbuf_port #(
  parameter int W         = 8,
  parameter int HALF_FAST = 2,
  parameter int HALF_MID  = 8,
  parameter int HALF_SLOW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_master,
  input  logic         cfg_cpol,
  input  logic         cfg_cke,
  input  logic         cfg_smp,
  input  logic [1:0]   cfg_rate,
  input  logic         cfg_ss_en,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  input  logic         host_rd,
  output logic [W-1:0] host_rdata,
  input  logic         clr_wcol,
  input  logic         clr_ovf,
  input  logic         clr_irq,
  output logic         stat_bf,
  output logic         stat_wcol,
  output logic         stat_ovf,
  output logic         irq,
  output logic         busy,
  output logic         sck_out,
  output logic         sck_oe,
  input  logic         sck_in,
  input  logic         ss_n,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe
);

  localparam int BW   = $clog2(W + 1);
  localparam int KW   = $clog2(2 * W + 2);
  localparam int DIVW = $clog2(HALF_SLOW);

  logic [W-1:0]    shreg, rbuf, sh_next;
  logic [BW-1:0]   bitcnt;
  logic [KW-1:0]   k, e;
  logic [DIVW-1:0] divcnt, half_m1;
  logic            m_busy, sck_ph, sdo_q;
  logic [1:0]      sck_sy, ss_sy, sdi_sy;
  logic            sck_d;

  always_comb begin
    case (cfg_rate)
      2'd0:    half_m1 = DIVW'(HALF_FAST - 1);
      2'd1:    half_m1 = DIVW'(HALF_MID - 1);
      default: half_m1 = DIVW'(HALF_SLOW - 1);
    endcase
  end

  assign e = k + 1'b1;

  logic m_tick, m_cap, m_launch, m_end;
  assign m_tick   = m_busy & (divcnt == half_m1);
  assign m_cap    = m_tick & (e[0] == (cfg_cke ^ cfg_smp)) & (bitcnt != BW'(W))
                  & ~((e == KW'(1)) & ~cfg_cke);
  assign m_launch = m_tick & (e[0] == ~cfg_cke) & (e <= KW'(2 * W));
  assign m_end    = m_tick & (e == KW'(2 * W + 1));

  logic s_act, lead, trail, s_cap, s_launch, s_done;
  assign s_act    = ~cfg_ss_en | ~ss_sy[1];
  assign lead     = (sck_d == cfg_cpol) & (sck_sy[1] != cfg_cpol);
  assign trail    = (sck_d != cfg_cpol) & (sck_sy[1] == cfg_cpol);
  assign s_cap    = ~cfg_master & s_act & (cfg_cke ? lead : trail);
  assign s_launch = ~cfg_master & s_act & (cfg_cke ? trail : lead);
  assign s_done   = s_cap & (bitcnt == BW'(W - 1));

  logic cap, launch, done, sdi_in, load, coll;
  assign cap    = cfg_master ? m_cap : s_cap;
  assign launch = cfg_master ? m_launch : s_launch;
  assign done   = cfg_master ? m_end : s_done;
  assign sdi_in = cfg_master ? sdi : sdi_sy[1];
  assign busy   = cfg_master ? m_busy : (bitcnt != '0);
  assign load   = host_wr & ~busy;
  assign coll   = host_wr & busy;

  assign sh_next = cap ? {shreg[W-2:0], sdi_in} : shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sck_d  <= 1'b0;
      ss_sy  <= 2'b11;
      sdi_sy <= '0;
    end else begin
      sck_sy <= {sck_sy[0], sck_in};
      sck_d  <= sck_sy[1];
      ss_sy  <= {ss_sy[0], ss_n};
      sdi_sy <= {sdi_sy[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sdo_q  <= 1'b0;
      bitcnt <= '0;
    end else begin
      if (load)        shreg <= host_wdata;
      else if (cap)    shreg <= sh_next;

      if (load)        sdo_q <= host_wdata[W-1];
      else if (launch) sdo_q <= cap ? shreg[W-2] : shreg[W-1];

      if (!cfg_master && !s_act)  bitcnt <= '0;
      else if (load && cfg_master) bitcnt <= '0;
      else if (done)               bitcnt <= '0;
      else if (cap)                bitcnt <= bitcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      k      <= '0;
      divcnt <= '0;
      sck_ph <= 1'b0;
    end else begin
      if (load && cfg_master) begin
        m_busy <= 1'b1;
        k      <= '0;
        divcnt <= '0;
      end else if (m_tick) begin
        divcnt <= '0;
        k      <= e;
        if (m_end) m_busy <= 1'b0;
      end else if (m_busy) begin
        divcnt <= divcnt + 1'b1;
      end

      if (m_tick && (e <= KW'(2 * W))) sck_ph <= ~sck_ph;
      else if (!m_busy)                sck_ph <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf      <= '0;
      stat_bf   <= 1'b0;
      stat_ovf  <= 1'b0;
      stat_wcol <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (done && (!stat_bf || host_rd)) rbuf <= sh_next;

      if (done)         stat_bf <= 1'b1;
      else if (host_rd) stat_bf <= 1'b0;

      if (done && stat_bf && !host_rd) stat_ovf <= 1'b1;
      else if (clr_ovf)                stat_ovf <= 1'b0;

      if (done)         irq <= 1'b1;
      else if (clr_irq) irq <= 1'b0;

      if (coll)          stat_wcol <= 1'b1;
      else if (clr_wcol) stat_wcol <= 1'b0;
    end
  end

  assign host_rdata = rbuf;
  assign sck_out    = sck_ph ^ cfg_cpol;
  assign sck_oe     = cfg_master;
  assign sdo        = sdo_q;
  assign sdo_oe     = cfg_master | s_act;

endmodule

// File: rtl/spi_dbuf_port_chk.sv
module spi_dbuf_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_master,
  input logic         cfg_cpol,
  input logic         cfg_ss_en,
  input logic         host_wr,
  input logic         host_rd,
  input logic [W-1:0] host_rdata,
  input logic         clr_wcol,
  input logic         clr_ovf,
  input logic         clr_irq,
  input logic         stat_bf,
  input logic         stat_wcol,
  input logic         stat_ovf,
  input logic         irq,
  input logic         busy,
  input logic         sck_out,
  input logic         sck_oe,
  input logic         ss_n,
  input logic         sdo_oe
);

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !busy |-> sck_out == cfg_cpol);

  // R4
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $fell(busy) |-> stat_bf && irq);

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !busy |=> !stat_bf);

  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && busy |=> stat_wcol);

  // R6
  wcol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wcol && !clr_wcol |=> stat_wcol);

  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ovf) |-> $stable(host_rdata));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovf && !clr_ovf |=> stat_ovf);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq);

  // R10
  master_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master |-> sdo_oe && sck_oe);

  // R10
  ss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master && cfg_ss_en && ss_n && $past(ss_n) && $past(ss_n, 2) |-> !sdo_oe);

endmodule

bind spi_dbuf_port spi_dbuf_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .cfg_ss_en(cfg_ss_en), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .clr_wcol(clr_wcol), .clr_ovf(clr_ovf),
  .clr_irq(clr_irq), .stat_bf(stat_bf), .stat_wcol(stat_wcol),
  .stat_ovf(stat_ovf), .irq(irq), .busy(busy), .sck_out(sck_out),
  .sck_oe(sck_oe), .ss_n(ss_n), .sdo_oe(sdo_oe)
);

// File: tb/spi_dbuf_port_bench.sv
module spi_dbuf_port_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cke = 1'b1, cfg_smp = 1'b0, cfg_ss_en = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic host_wr = 1'b0, host_rd = 1'b0, clr_wcol = 1'b0, clr_ovf = 1'b0, clr_irq = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] host_rdata;
  logic stat_bf, stat_wcol, stat_ovf, irq, busy, sck_out, sck_oe, sdo, sdo_oe;
  logic sck_in = 1'b0, ss_n = 1'b1, p_sdi = 1'b0, s_sdi = 1'b0;
  logic sdi;
  assign sdi = cfg_master ? p_sdi : s_sdi;

  spi_dbuf_port #(.W(W)) u_spi_dbuf_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cke(cfg_cke), .cfg_smp(cfg_smp), .cfg_rate(cfg_rate), .cfg_ss_en(cfg_ss_en),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .clr_irq(clr_irq), .stat_bf(stat_bf),
    .stat_wcol(stat_wcol), .stat_ovf(stat_ovf), .irq(irq), .busy(busy),
    .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in), .ss_n(ss_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [W-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // partner device model used while the port is master
  bit p_on = 1'b0;
  logic p_cpol = 1'b0, p_cke = 1'b1, sck_prev = 1'b0, p_lead;
  logic [W-1:0] p_rx = '0, p_got = '0;
  int p_idx = 0, p_edges = 0;
  always @(negedge clk) begin
    if (p_on && sck_out != sck_prev) begin
      p_edges++;
      p_lead = (sck_out != p_cpol);
      if (p_lead == p_cke) p_got = {p_got[W-2:0], sdo};
      else if (p_cke) begin
        if (p_idx > 0) begin p_idx--; p_sdi = p_rx[p_idx]; end
      end else begin
        p_sdi = p_rx[p_idx];
        if (p_idx > 0) p_idx--;
      end
    end
    sck_prev = sck_out;
  end

  // scoreboard monitor: each rise of the buffer-full flag pops one expected byte
  logic bf_prev = 1'b0;
  logic [W-1:0] m_exp;
  always @(negedge clk) begin
    if (rst_n && stat_bf && !bf_prev) begin
      if (expq.size() == 0) chk(1'b0, "R4 unexpected byte", host_rdata, 0);
      else begin
        m_exp = expq.pop_front();
        chk(host_rdata == m_exp, "R4 received byte", host_rdata, m_exp);
        chk(irq == 1'b1, "R4 irq with buffer full", irq, 1);
      end
    end
    bf_prev = stat_bf;
  end

  task automatic m_xfer(input logic [W-1:0] tx, input logic [W-1:0] rx, input logic cpol,
                        input logic cke, input logic smp, input logic [1:0] rate,
                        input bit push, input bit collide);
    int half, cnt;
    half = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 8 : 32;
    @(negedge clk);
    cfg_master = 1'b1; cfg_cpol = cpol; cfg_cke = cke; cfg_smp = smp; cfg_rate = rate;
    repeat (3) @(negedge clk);
    chk(sck_out == cpol, "R2 sck idle before", sck_out, cpol);
    p_cpol = cpol; p_cke = cke; p_rx = rx; p_idx = W - 1; p_got = '0; p_edges = 0;
    p_sdi = cke ? rx[W-1] : 1'b0;
    sck_prev = sck_out; p_on = 1'b1;
    if (push) expq.push_back(rx);
    host_wdata = tx; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      if (collide && cnt == 5) begin host_wdata = ~tx; host_wr = 1'b1; end
      @(negedge clk);
      host_wr = 1'b0;
      if (collide && cnt == 5) chk(stat_wcol, "R6 wcol on busy write", stat_wcol, 1);
    end
    p_on = 1'b0;
    chk(cnt == 17 * half, "R2 transfer length", cnt, 17 * half);
    chk(p_edges == 16, "R2 sck toggle count", p_edges, 16);
    chk(p_got == tx, "R1 R3 byte seen on sdo", p_got, tx);
    chk(sck_out == cpol, "R2 sck idle after", sck_out, cpol);
  endtask

  task automatic host_read(input logic [W-1:0] exp);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk(stat_bf == 1'b0, "R5 read clears bf", stat_bf, 0);
    chk(host_rdata == exp, "R5 data kept after read", host_rdata, exp);
  endtask

  task automatic pulse_clr_irq();
    @(negedge clk); clr_irq = 1'b1;
    @(negedge clk); clr_irq = 1'b0;
    chk(irq == 1'b0, "R8 clr_irq clears irq", irq, 0);
  endtask

  task automatic s_clock(input logic [W-1:0] rx, input logic cke, input int nbits,
                         output logic [W-1:0] got);
    got = '0;
    if (cke) s_sdi = rx[W-1];
    for (int i = 0; i < nbits; i++) begin
      if (cke) begin
        got = {got[W-2:0], sdo};
        sck_in = ~cfg_cpol;
        repeat (8) @(negedge clk);
        sck_in = cfg_cpol;
        if (i < W - 1) s_sdi = rx[W-2-i];
        repeat (8) @(negedge clk);
      end else begin
        sck_in = ~cfg_cpol;
        s_sdi = rx[W-1-i];
        repeat (8) @(negedge clk);
        got = {got[W-2:0], sdo};
        sck_in = cfg_cpol;
        repeat (8) @(negedge clk);
      end
    end
  endtask

  task automatic host_write(input logic [W-1:0] d);
    @(negedge clk); host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  initial begin
    logic [W-1:0] got;
    repeat (3) @(negedge clk);
    chk(stat_bf == 0 && stat_wcol == 0 && stat_ovf == 0 && irq == 0, "R11 flags in reset",
        {stat_bf, stat_wcol, stat_ovf, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy after reset", busy, 0);
    chk(sck_out == cfg_cpol, "R11 sck idle after reset", sck_out, cfg_cpol);
    chk(sdo_oe && sck_oe, "R10 master drives pins", {sdo_oe, sck_oe}, 3);

    m_xfer(8'hA5, 8'h3C, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0);
    host_read(8'h3C);
    chk(irq == 1'b1, "R8 irq survives read", irq, 1);
    pulse_clr_irq();

    m_xfer(8'h96, 8'h5A, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
    host_read(8'h5A); pulse_clr_irq();
    m_xfer(8'h01, 8'h80, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0);
    host_read(8'h80); pulse_clr_irq();
    m_xfer(8'hFE, 8'h7F, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0);
    host_read(8'h7F); pulse_clr_irq();
    m_xfer(8'h4D, 8'hB2, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0);
    host_read(8'hB2); pulse_clr_irq();

    // R6: collision during a transfer
    m_xfer(8'h3C, 8'hC3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1);
    chk(stat_wcol == 1'b1, "R6 wcol sticky", stat_wcol, 1);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R6 discarded write starts nothing", busy, 0);
    host_read(8'hC3);
    @(negedge clk); clr_wcol = 1'b1;
    @(negedge clk); clr_wcol = 1'b0;
    chk(stat_wcol == 1'b0, "R6 clr_wcol clears", stat_wcol, 0);
    pulse_clr_irq();

    // R7: overflow keeps the old byte
    m_xfer(8'h11, 8'h22, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0);
    chk(stat_ovf == 1'b0, "R7 no overflow yet", stat_ovf, 0);
    m_xfer(8'h33, 8'h44, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    chk(stat_ovf == 1'b1, "R7 overflow set", stat_ovf, 1);
    chk(host_rdata == 8'h22, "R7 old byte kept", host_rdata, 8'h22);
    host_read(8'h22);
    chk(stat_ovf == 1'b1, "R7 overflow survives read", stat_ovf, 1);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    chk(stat_ovf == 1'b0, "R7 clr_ovf clears", stat_ovf, 0);
    pulse_clr_irq();

    // R9: slave, launch on active-to-idle, select ignored
    @(negedge clk); cfg_cpol = 1'b1; sck_in = 1'b1;
    repeat (4) @(negedge clk);
    cfg_master = 1'b0; cfg_cke = 1'b1; cfg_ss_en = 1'b0; ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b1, "R10 select ignored when disabled", sdo_oe, 1);
    host_write(8'h6B);
    expq.push_back(8'hD2);
    s_clock(8'hD2, 1'b1, 8, got);
    repeat (6) @(negedge clk);
    chk(got == 8'h6B, "R9 R1 slave byte on sdo", got, 8'h6B);
    host_read(8'hD2); pulse_clr_irq();

    // R9 R10: slave, launch on idle-to-active, with select gating
    @(negedge clk); cfg_cpol = 1'b0; sck_in = 1'b0; cfg_cke = 1'b0; cfg_ss_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0, "R10 deselected output off", sdo_oe, 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b1, "R10 selected output on", sdo_oe, 1);
    host_write(8'h0F);
    s_clock(8'hE0, 1'b0, 3, got);
    chk(busy == 1'b1, "R9 partial byte in progress", busy, 1);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 deselect drops partial byte", busy, 0);
    chk(sdo_oe == 1'b0, "R10 output off after deselect", sdo_oe, 0);
    chk(stat_bf == 1'b0, "R10 no byte from partial", stat_bf, 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    host_write(8'hC6);
    expq.push_back(8'h5A);
    s_clock(8'h5A, 1'b0, 8, got);
    repeat (6) @(negedge clk);
    chk(got == 8'hC6, "R9 R3 slave byte on sdo", got, 8'hC6);
    host_read(8'h5A);

    chk(expq.size() == 0, "R4 all bytes delivered", expq.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule